// File: doc/BRIEF.md
# Bit-Field Execution Unit

This unit performs one bit-field operation per accepted request on a 32-bit register operand. A field is chosen by an offset and a width. Positions count from the most significant bit, which is position 0, toward the right. A field may start at any position. It may be 1 to 32 bits long, and it wraps from position 31 back to position 0. Eight operations are available: test, clear, set, flip, unsigned extract, signed extract, insert, and find-first-one. Each request returns four things: the operand after any change to the field, a 32-bit result value, the N/Z/V/C flags, and an indication that the extend flag must keep its old value.

Requests arrive on a valid/ready stream, and results leave on a second valid/ready stream. There is one register stage between them. An accepted request produces its result on the next cycle. Back-pressure works as follows:
- `in_ready` is high while the output register is empty, or while its content is being taken in the same cycle.
- While `out_valid` is high and `out_ready` is low, every output stays frozen.
- While `out_valid` is high and `out_ready` is low, no new request is accepted.

Top module: `bitfield_unit`

## Requirements
- R1: Field position p maps to operand bit 31-p. A field of width w at offset o covers positions o, o+1, ..., o+w-1.
- R2: `in_width` holds the field width, and code 0 means 32 bits. Only the low 5 bits of `in_offset` select the start position. A field that runs past position 31 continues at position 0.
- R3: Opcodes 0 (test), 1 (clear), 2 (set) and 3 (flip) compute the flags from the field contents before any change. Opcode 0 leaves the operand unchanged. Opcodes 1, 2 and 3 return the operand with the field set to all 0, set to all 1, or inverted. Opcodes 4, 5 and 7 also return the operand unchanged.
- R4: N is the leftmost field bit and Z is set when all field bits are 0. V and C are always 0, and `out_x_keep` is always 1.
- R5: Opcode 4 returns the field right-justified and zero-filled in `out_result`.
- R6: Opcode 5 returns the field right-justified and sign-extended to 32 bits from its leftmost bit.
- R7: Opcode 6 writes the low w bits of `in_src` into the field. Its N and Z are computed from those inserted bits.
- R8: Opcode 7 returns the full 32-bit `in_offset` plus the index, within the field, of the leftmost 1. If the field holds no 1, it returns `in_offset` plus w. The addition wraps at 32 bits.
- R9: Opcodes 0, 1, 2, 3 and 6 return 0 in `out_result`.
- R10: `in_ready` equals (not `out_valid`) or `out_ready`. An accepted request appears on the outputs in the next cycle. The outputs stay stable while stalled.
- R11: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken |
| in_op | input | 3 | Operation code |
| in_operand | input | 32 | Register operand |
| in_offset | input | 32 | Signed field offset |
| in_width | input | 5 | Field width, 0 means 32 |
| in_src | input | 32 | Insert source |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_operand | output | 32 | Operand after the operation |
| out_result | output | 32 | Extract or find-first-one result |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |
| out_x_keep | output | 1 | Extend flag to be left unchanged |

## Verification
The bench builds the unit with its default data width of 32. At that width, 5-bit positions and the width code 0 (meaning 32) cover every field the requirements describe. Three kinds of case are reached:
- Fields that wrap past position 31.
- Negative offsets added into find-first-one results.
- Full-width extracts.

A table of mixed operations is checked against a bit-by-bit reference model in the bench. Directed cases with hand-computed values and a stall sequence then exercise the wrap, empty-field and back-pressure rules.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [2:0] {
    BF_TEST   = 3'd0,
    BF_CLEAR  = 3'd1,
    BF_SET    = 3'd2,
    BF_FLIP   = 3'd3,
    BF_XU     = 3'd4,
    BF_XS     = 3'd5,
    BF_INSERT = 3'd6,
    BF_FIRST1 = 3'd7
  } bf_op_e;
endpackage

// File: rtl/bf_rotator.sv
// Barrel rotation of a word; direction chosen by parameter.
module bf_rotator #(
  parameter int W      = 32,
  parameter int SH_W   = $clog2(W),
  parameter bit LEFT   = 1'b1
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    dout
);
  logic [2*W-1:0] twice;
  logic [2*W-1:0] shifted;

  assign twice = {din, din};

  generate
    if (LEFT) begin : g_left
      assign shifted = twice << amt;
      assign dout    = shifted[2*W-1:W];
    end else begin : g_right
      assign shifted = twice >> amt;
      assign dout    = shifted[W-1:0];
    end
  endgenerate
endmodule

// File: rtl/bf_lead_one.sv
// Leading-zero count: index of the highest set bit counted from the top,
// W when the input is zero.
module bf_lead_one #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     din,
  output logic [CNT_W-1:0] lead
);
  always_comb begin
    lead = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) lead = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/bf_field_core.sv
// Combinational bit-field datapath.
module bf_field_core
  import bf_pkg::*;
#(
  parameter int W     = 32,
  parameter int POS_W = $clog2(W),
  parameter int CNT_W = $clog2(W + 1)
) (
  input  bf_op_e           op,
  input  logic [W-1:0]     operand,
  input  logic [W-1:0]     offset,
  input  logic [POS_W-1:0] width_code,
  input  logic [W-1:0]     src,
  output logic [W-1:0]     new_operand,
  output logic [W-1:0]     result,
  output logic             flag_n,
  output logic             flag_z
);
  logic [POS_W-1:0] start;
  logic [CNT_W-1:0] w_eff;
  logic [CNT_W-1:0] rsh;
  logic [W-1:0]     aligned;      // field moved to the top
  logic [W-1:0]     top_mask;     // top w bits set
  logic [W-1:0]     field_top;
  logic [W-1:0]     place_mask;   // mask in operand bit order
  logic [W-1:0]     ins_top;
  logic [W-1:0]     ins_place;
  logic [W-1:0]     zext;
  logic [W-1:0]     sext;
  logic [CNT_W-1:0] lead;
  logic [W-1:0]     first_idx;
  logic             fld_zero;

  assign start    = offset[POS_W-1:0];
  assign w_eff    = (width_code == '0) ? CNT_W'(W) : CNT_W'(width_code);
  assign rsh      = CNT_W'(W) - w_eff;
  assign top_mask = ~({W{1'b1}} >> w_eff);

  bf_rotator #(.W(W), .SH_W(POS_W), .LEFT(1'b1)) u_align (
    .din(operand), .amt(start), .dout(aligned)
  );

  assign field_top = aligned & top_mask;
  assign fld_zero  = (field_top == '0);

  bf_rotator #(.W(W), .SH_W(POS_W), .LEFT(1'b0)) u_mask (
    .din(top_mask), .amt(start), .dout(place_mask)
  );

  assign ins_top = src << rsh;

  bf_rotator #(.W(W), .SH_W(POS_W), .LEFT(1'b0)) u_ins (
    .din(ins_top), .amt(start), .dout(ins_place)
  );

  bf_lead_one #(.W(W), .CNT_W(CNT_W)) u_lead (
    .din(field_top), .lead(lead)
  );

  assign zext      = aligned >> rsh;
  assign sext      = W'($signed(aligned) >>> rsh);
  assign first_idx = offset + W'(fld_zero ? w_eff : lead);

  always_comb begin
    new_operand = operand;
    result      = '0;
    flag_n      = aligned[W-1];
    flag_z      = fld_zero;
    unique case (op)
      BF_TEST:   new_operand = operand;
      BF_CLEAR:  new_operand = operand & ~place_mask;
      BF_SET:    new_operand = operand | place_mask;
      BF_FLIP:   new_operand = operand ^ place_mask;
      BF_XU:     result      = zext;
      BF_XS:     result      = sext;
      BF_INSERT: begin
        new_operand = (operand & ~place_mask) | (ins_place & place_mask);
        flag_n      = ins_top[W-1];
        flag_z      = (ins_top == '0);
      end
      BF_FIRST1: result      = first_idx;
      default:   result      = '0;
    endcase
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bf_pkg::*;
#(
  parameter int W     = 32,
  parameter int POS_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [W-1:0]     in_operand,
  input  logic [W-1:0]     in_offset,
  input  logic [POS_W-1:0] in_width,
  input  logic [W-1:0]     in_src,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_operand,
  output logic [W-1:0]     out_result,
  output logic             out_n,
  output logic             out_z,
  output logic             out_v,
  output logic             out_c,
  output logic             out_x_keep
);
  logic [W-1:0] c_operand;
  logic [W-1:0] c_result;
  logic         c_n;
  logic         c_z;
  logic         take;

  bf_field_core #(.W(W), .POS_W(POS_W)) u_core (
    .op(bf_op_e'(in_op)),
    .operand(in_operand),
    .offset(in_offset),
    .width_code(in_width),
    .src(in_src),
    .new_operand(c_operand),
    .result(c_result),
    .flag_n(c_n),
    .flag_z(c_z)
  );

  assign in_ready   = !out_valid || out_ready;
  assign take       = in_valid && in_ready;
  assign out_v      = 1'b0;
  assign out_c      = 1'b0;
  assign out_x_keep = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_operand <= '0;
      out_result  <= '0;
      out_n       <= 1'b0;
      out_z       <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_operand <= c_operand;
        out_result  <= c_result;
        out_n       <= c_n;
        out_z       <= c_z;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
  parameter int W     = 32,
  parameter int POS_W = $clog2(W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic [W-1:0]     in_operand,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_operand,
  input logic [W-1:0]     out_result,
  input logic             out_n,
  input logic             out_z
);
  a_r10_accept_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r10_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_operand) &&
      $stable(out_result) && $stable(out_n) && $stable(out_z)));

  a_r3_test_keeps_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'd0) |=> (out_operand == $past(in_operand)));

  a_r5_extract_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'd4) |=> (out_z == (out_result == '0)));

  a_r9_no_result_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'd1) |=> (out_result == '0));
endmodule

bind bitfield_unit bitfield_unit_chk #(.W(W), .POS_W(POS_W)) chk_i (.*);

// File: tb/bitfield_unit_tb_top.sv
module bitfield_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] opnd;
    logic [31:0] off;
    logic [4:0]  wc;
    logic [31:0] src;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h1234_5678, 32'd4,  5'd8,  32'h0},
    '{3'd1, 32'hDEAD_BEEF, 32'd10, 5'd12, 32'h0},
    '{3'd2, 32'h0000_0000, 32'd28, 5'd9,  32'h0},
    '{3'd3, 32'hA5A5_5A5A, 32'd3,  5'd0,  32'h0},
    '{3'd4, 32'hCAFE_F00D, 32'd7,  5'd13, 32'h0},
    '{3'd5, 32'hCAFE_F00D, 32'd0,  5'd4,  32'h0},
    '{3'd5, 32'h0F0F_0F0F, 32'd29, 5'd6,  32'h0},
    '{3'd6, 32'h1111_1111, 32'd20, 5'd8,  32'hFFFF_FF9C},
    '{3'd6, 32'hFFFF_0000, 32'd30, 5'd5,  32'h0000_0013},
    '{3'd7, 32'h0004_0000, 32'd2,  5'd20, 32'h0},
    '{3'd7, 32'h8000_0000, 32'hFFFF_FFF0, 5'd24, 32'h0},
    '{3'd4, 32'h7654_3210, 32'h0000_0044, 5'd8, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [31:0] in_operand = '0;
  logic [31:0] in_offset = '0;
  logic [4:0]  in_width = '0;
  logic [31:0] in_src = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_operand;
  logic [31:0] out_result;
  logic        out_n, out_z, out_v, out_c, out_x_keep;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitfield_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_operand(in_operand), .in_offset(in_offset), .in_width(in_width),
    .in_src(in_src),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_operand(out_operand), .out_result(out_result),
    .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_c(out_c),
    .out_x_keep(out_x_keep)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model built bit by bit from the requirements.
  task automatic model(input vec_t v, output logic [31:0] e_opnd,
                       output logic [31:0] e_res, output logic e_n, output logic e_z);
    int w;
    int st;
    logic [31:0] fld;
    int first;
    w  = (v.wc == 0) ? 32 : int'(v.wc);
    st = int'(v.off[4:0]);
    fld = '0;
    first = -1;
    e_opnd = v.opnd;
    for (int k = 0; k < w; k++) begin
      int p;
      p = (st + k) % 32;
      fld = {fld[30:0], v.opnd[31-p]};
      if (v.opnd[31-p] && first < 0) first = k;
      case (v.op)
        3'd1: e_opnd[31-p] = 1'b0;
        3'd2: e_opnd[31-p] = 1'b1;
        3'd3: e_opnd[31-p] = ~v.opnd[31-p];
        3'd6: e_opnd[31-p] = v.src[w-1-k];
        default: ;
      endcase
    end
    e_n = fld[w-1];
    e_z = (fld == 0);
    e_res = '0;
    case (v.op)
      3'd4: e_res = fld;
      3'd5: begin
        e_res = fld;
        for (int b = w; b < 32; b++) e_res[b] = fld[w-1];
      end
      3'd6: begin
        logic [31:0] ins;
        ins = '0;
        for (int b = 0; b < w; b++) ins[b] = v.src[b];
        e_n = ins[w-1];
        e_z = (ins == 0);
      end
      3'd7: e_res = v.off + ((first < 0) ? 32'(w) : 32'(first));
      default: ;
    endcase
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    in_op = v.op; in_operand = v.opnd; in_offset = v.off;
    in_width = v.wc; in_src = v.src; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic direct(input string tag, input vec_t v, input logic [31:0] e_opnd,
                        input logic [31:0] e_res, input logic e_n, input logic e_z);
    issue(v);
    check({tag, " valid"}, 32'(out_valid), 32'd1);
    check({tag, " operand"}, out_operand, e_opnd);
    check({tag, " result"}, out_result, e_res);
    check({tag, " n"}, 32'(out_n), 32'(e_n));
    check({tag, " z"}, 32'(out_z), 32'(e_z));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] e_opnd, e_res;
    logic e_n, e_z;
    vec_t a, b;

    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after reset", 32'(out_valid), 32'd0);
    check("R10 in_ready idle", 32'(in_ready), 32'd1);

    // Table walk: R1 R3 R5 R6 R7 R8 R9 against reference model
    for (int i = 0; i < NV; i++) begin
      model(VECS[i], e_opnd, e_res, e_n, e_z);
      issue(VECS[i]);
      check($sformatf("R1/R3 vec%0d operand", i), out_operand, e_opnd);
      check($sformatf("R5/R6/R8/R9 vec%0d result", i), out_result, e_res);
      check($sformatf("R4/R7 vec%0d n", i), 32'(out_n), 32'(e_n));
      check($sformatf("R4/R7 vec%0d z", i), 32'(out_z), 32'(e_z));
      check($sformatf("R4 vec%0d v/c/x", i), {29'd0, out_v, out_c, out_x_keep}, 32'd1);
    end

    // R5 field 13:12 of all ones
    direct("R5 extu 13:12", '{3'd4, 32'hFFFF_FFFF, 32'd13, 5'd12, 32'h0},
           32'hFFFF_FFFF, 32'h0000_0FFF, 1'b1, 1'b0);
    // R6 same field signed
    direct("R6 exts 13:12", '{3'd5, 32'hFFFF_FFFF, 32'd13, 5'd12, 32'h0},
           32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
    // R2 width code 0 means 32
    direct("R2 width 32", '{3'd4, 32'h8000_0001, 32'd0, 5'd0, 32'h0},
           32'h8000_0001, 32'h8000_0001, 1'b1, 1'b0);
    // R2 wrap: positions 30,31,0,1
    direct("R2 wrap clear", '{3'd1, 32'hFFFF_FFFF, 32'd30, 5'd4, 32'h0},
           32'h3FFF_FFFC, 32'h0, 1'b1, 1'b0);
    // R7 insert 101 at top
    direct("R7 insert", '{3'd6, 32'h0000_0000, 32'd0, 5'd3, 32'h0000_0005},
           32'hA000_0000, 32'h0, 1'b1, 1'b0);
    // R7 zero inserted gives Z
    direct("R7 insert zero", '{3'd6, 32'hFFFF_FFFF, 32'd4, 5'd4, 32'hFFFF_FFF0},
           32'hF0FF_FFFF, 32'h0, 1'b0, 1'b1);
    // R8 empty field
    direct("R8 ffo empty", '{3'd7, 32'h0, 32'd5, 5'd7, 32'h0},
           32'h0, 32'd12, 1'b0, 1'b1);
    // R8 one at position 15
    direct("R8 ffo hit", '{3'd7, 32'h0001_0000, 32'd8, 5'd16, 32'h0},
           32'h0001_0000, 32'd15, 1'b0, 1'b0);
    // R8 negative offset, empty and hit at last bit
    direct("R8 ffo neg empty", '{3'd7, 32'h0, 32'hFFFF_FFFC, 5'd8, 32'h0},
           32'h0, 32'd4, 1'b0, 1'b1);
    direct("R8 ffo neg hit", '{3'd7, 32'h0000_0001, 32'hFFFF_FFFC, 5'd8, 32'h0},
           32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 1'b0);
    // R3 flip flags from original field
    direct("R3 flip", '{3'd3, 32'h0F00_0000, 32'd0, 5'd8, 32'h0},
           32'hF000_0000, 32'h0, 1'b0, 1'b0);

    // R10 stall behaviour
    a = '{3'd4, 32'h1234_5678, 32'd0, 5'd8, 32'h0};
    b = '{3'd4, 32'h1234_5678, 32'd8, 5'd8, 32'h0};
    @(negedge clk);
    out_ready = 1'b0;
    in_op = a.op; in_operand = a.opnd; in_offset = a.off; in_width = a.wc;
    in_src = a.src; in_valid = 1'b1;
    @(negedge clk);
    check("R10 first accepted", 32'(out_valid), 32'd1);
    check("R10 ready low when full", 32'(in_ready), 32'd0);
    in_op = b.op; in_operand = b.opnd; in_offset = b.off; in_width = b.wc;
    in_src = b.src;
    @(negedge clk);
    check("R10 held result", out_result, 32'h0000_0012);
    check("R10 still ready low", 32'(in_ready), 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second after release", out_result, 32'h0000_0034);
    check("R10 valid after release", 32'(out_valid), 32'd1);
    @(negedge clk);
    check("R10 drained", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule